// File: doc/BRIEF.md
# Peripheral clock mux-divide-gate chain

This block produces one peripheral clock from four reference clocks. A crystal input is also available. The clock path has three stages in series. A source multiplexer comes first. A ratio stage follows it, built from two cascaded 3-bit integer divider codes. A clock gate comes last, and it is switched off by a disable bit. Software programs the block through a small word-addressed register bank. The bank has six registers: source select, three divider words, clock select and clock disable. The block runs entirely in the fabric clock domain. Every reference input passes through a synchroniser. The output is rebuilt by counting both edges of the selected source, which gives a 50% duty cycle for every ratio, odd ones included.

Changes to the source, and invalid divider codes, never cut a high phase short. The generator first finishes its current high phase. It then parks low, takes the new selection, and restarts with a full phase. A new divider ratio is loaded only when the output rises. Two reduced builds are selected by parameter:
- A single-divider build, which decodes one field through a table.
- A gate-only build, which passes the crystal input through the gate.

Software that restores the configuration after a power-down should write the registers in this order: the disable word, the divider words in ascending address order, the source word, then the clock-select word.

Top module: `pclk_chain`

## Requirements
- R1: The six registers sit at byte offsets 0x00 (source), 0x04, 0x08, 0x0C (divider words), 0x10 (clock select) and 0x14 (clock disable). A read returns the last value written to that offset. A read of any other offset returns 0.
- R2: After reset, every register reads 0 except the 0x04 word, which reads 0x09. That value puts divider code 1 in bits [2:0] and in bits [5:3]. The output clock is low while reset is held.
- R3: Bits [1:0] of the source register choose reference input 0 to 3. When both codes are 1, the output period equals the period of the chosen reference.
- R4: In the full build, the output period is c1×c2 source periods. Here c1 is bits [2:0] and c2 is bits [5:3] of word 0x04. The high time equals the low time, for odd products as well as even ones.
- R5: A code of 0 or 7 in either divider field holds the output low once its current high phase has ended. Writing valid codes again restarts the output.
- R6: When bit 0 of word 0x14 is 1, the output is held low. A high phase already in progress always completes at full width. Clearing the bit restores the clock.
- R7: A change of source never produces a high phase shorter than a full high phase of the old setting or the new one. After the change, the period follows the new source.
- R8: A new divider value takes effect at the next output rising edge. A low phase already under way keeps the old length.
- R9: When bit 0 of word 0x10 is 1, the crystal input becomes the source, and the source field is ignored.
- R10: The single-divider build, in its two-to-four table mode, divides by 2 when bit 0 of word 0x04 is 0 and by 4 when it is 1. All other bits of that word have no effect.
- R11: The gate-only build outputs the crystal clock unchanged and ignores the source and divider words. Its disable bit still stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock; samples references and runs the bank |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | NREF (4) | Reference clock inputs, index 0 to 3 |
| xtal_i | input | 1 | Crystal clock input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | AW (5) | Register byte address |
| bus_wdata_i | input | DW (32) | Register write data |
| bus_rdata_o | output | DW (32) | Register read data for bus_addr_i |
| pclk_o | output | 1 | Gated peripheral clock output |

## Verification
Each reference input is selected in turn with unit ratio, and each has a distinct period, so an indexing error in the multiplexer shows up as a wrong period. Products such as 2×3, 5×1, 3×3 and 6×6 separate a true product from a sum or a single field, and the odd products expose any duty-cycle asymmetry. Writes are placed three cycles into a high phase. The width of that high phase and of the low phase after it separate a deferred divider load, a source switch or a gate action from an immediate one that would cut the pulse. Invalid codes are tried in each field separately, and the two reduced builds are checked to ignore the fields they do not use.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

   typedef enum logic [1:0] {
      VAR_FULL  = 2'd0,
      VAR_TABLE = 2'd1,
      VAR_GATE  = 2'd2
   } pclk_variant_e;

   typedef enum logic [1:0] {
      TBL_SIX      = 2'd0,
      TBL_ONE_TWO  = 2'd1,
      TBL_TWO_FOUR = 2'd2
   } pclk_table_e;

   localparam int NUM_REGS   = 6;
   localparam int REG_SRC    = 0;
   localparam int REG_CLKSEL = 4;
   localparam int REG_DIS    = 5;

   // a divider code is usable when it lies in 1..6
   function automatic logic code_ok(input logic [2:0] code);
      return (code != 3'd0) && (code != 3'd7);
   endfunction

endpackage

// File: rtl/pclk_regs.sv
module pclk_regs import pclk_pkg::*; #(
   parameter int            DW      = 32,
   parameter int            AW      = 5,
   parameter int            RST_IDX = 1,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             wr_i,
   input  logic [AW-1:0]                    addr_i,
   input  logic [DW-1:0]                    wdata_i,
   output logic [DW-1:0]                    rdata_o,
   output logic [NUM_REGS-1:0][DW-1:0]      cfg_o
);

   localparam int IW = AW - 2;

   logic          aligned;
   logic [IW-1:0] word_idx;

   assign aligned  = (addr_i[1:0] == 2'b00);
   assign word_idx = addr_i[AW-1:2];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int r = 0; r < NUM_REGS; r++)
            cfg_o[r] <= (r == RST_IDX) ? RST_VAL : '0;
      end else if (wr_i && aligned) begin
         for (int r = 0; r < NUM_REGS; r++)
            if (word_idx == IW'(r)) cfg_o[r] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (aligned)
         for (int k = 0; k < NUM_REGS; k++)
            if (word_idx == IW'(k)) rdata_o = cfg_o[k];
   end

endmodule

// File: rtl/pclk_srcsel.sv
module pclk_srcsel #(
   parameter  int NIN         = 5,
   parameter  int SYNC_STAGES = 2,
   localparam int SW          = $clog2(NIN)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NIN-1:0] src_i,
   input  logic [SW-1:0]  sel_i,
   output logic           lvl_o
);

   logic [NIN-1:0] synced;

   for (genvar g = 0; g < NIN; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pipe_q <= '0;
         else         pipe_q <= {pipe_q[SYNC_STAGES-2:0], src_i[g]};
      end
      assign synced[g] = pipe_q[SYNC_STAGES-1];
   end

   always_comb begin
      lvl_o = 1'b0;
      for (int k = 0; k < NIN; k++)
         if (sel_i == SW'(k)) lvl_o = synced[k];
   end

endmodule

// File: rtl/pclk_shaper.sv
module pclk_shaper #(
   parameter int SW   = 3,
   parameter int CNTW = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            src_lvl_i,
   input  logic [SW-1:0]   req_sel_i,
   input  logic [CNTW-1:0] ratio_i,
   input  logic            ratio_ok_i,
   input  logic            dis_i,
   output logic [SW-1:0]   cur_sel_o,
   output logic            div_q_o,
   output logic            gate_en_o,
   output logic [CNTW-1:0] act_n_o,
   output logic            hold_o,
   output logic            clk_o
);

   typedef enum logic {ST_HOLD, ST_RUN} shp_state_e;

   shp_state_e      st_q;
   logic            src_q, div_q, gate_en_q, clk_q;
   logic [CNTW-1:0] cnt_q, act_n_q;
   logic [SW-1:0]   cur_sel_q;
   logic            src_edge, stop_req;

   // both edges of the source count, so a ratio N means N half-periods per phase
   assign src_edge = (src_lvl_i != src_q) && (st_q == ST_RUN);
   assign stop_req = !ratio_ok_i || (req_sel_i != cur_sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_HOLD;
         src_q     <= 1'b0;
         div_q     <= 1'b0;
         cnt_q     <= '0;
         act_n_q   <= CNTW'(1);
         cur_sel_q <= '0;
         gate_en_q <= 1'b1;
         clk_q     <= 1'b0;
      end else begin
         src_q <= src_lvl_i;
         if (!div_q) gate_en_q <= !dis_i;
         clk_q <= div_q & gate_en_q;
         unique case (st_q)
            ST_HOLD: begin
               if (stop_req) begin
                  cur_sel_q <= req_sel_i;
               end else begin
                  st_q    <= ST_RUN;
                  act_n_q <= ratio_i;
                  cnt_q   <= '0;
               end
            end
            ST_RUN: begin
               if (stop_req && !div_q) begin
                  st_q      <= ST_HOLD;
                  cur_sel_q <= req_sel_i;
                  cnt_q     <= '0;
               end else if (src_edge) begin
                  if (cnt_q == act_n_q - CNTW'(1)) begin
                     cnt_q <= '0;
                     div_q <= !div_q;
                     if (!div_q) act_n_q <= ratio_i;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
            end
            default: st_q <= ST_HOLD;
         endcase
      end
   end

   assign cur_sel_o = cur_sel_q;
   assign div_q_o   = div_q;
   assign gate_en_o = gate_en_q;
   assign act_n_o   = act_n_q;
   assign hold_o    = (st_q == ST_HOLD);
   assign clk_o     = clk_q;

endmodule

// File: rtl/pclk_chain.sv
module pclk_chain import pclk_pkg::*; #(
   parameter pclk_variant_e VARIANT     = VAR_FULL,
   parameter pclk_table_e   TABLE_MODE  = TBL_SIX,
   parameter int            NREF        = 4,
   parameter int            DW          = 32,
   parameter int            AW          = 5,
   parameter int            DIV_REG     = 1,
   parameter int            DIV1_LSB    = 0,
   parameter int            DIV2_LSB    = 3,
   parameter int            SRC_LSB     = 0,
   parameter int            BYP_BIT     = 0,
   parameter int            GATE_BIT    = 0,
   parameter int            SYNC_STAGES = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NREF-1:0] ref_clk_i,
   input  logic            xtal_i,
   input  logic            bus_wr_i,
   input  logic [AW-1:0]   bus_addr_i,
   input  logic [DW-1:0]   bus_wdata_i,
   output logic [DW-1:0]   bus_rdata_o,
   output logic            pclk_o
);

   localparam int SEL_W    = $clog2(NREF);
   localparam int NSRC     = NREF + 1;
   localparam int SW       = $clog2(NSRC);
   localparam int CODE_W   = 3;
   localparam int CNTW     = 2 * CODE_W;
   localparam int XTAL_IDX = NREF;
   localparam logic [DW-1:0] DIV_RST = (DW'(1) << DIV1_LSB) | (DW'(1) << DIV2_LSB);

   if ((1 << SEL_W) != NREF || NREF < 2) begin : g_bad_nref
      $error("NREF must be a power of two of at least 2");
   end
   if (DIV_REG < 1 || DIV_REG > 3) begin : g_bad_divreg
      $error("DIV_REG must name one of the three divider words");
   end
   if (DIV1_LSB + CODE_W > DW || DIV2_LSB + CODE_W > DW || SRC_LSB + SEL_W > DW) begin : g_bad_field
      $error("a control field lies outside the register width");
   end
   if (SYNC_STAGES < 2 || AW < 5) begin : g_bad_misc
      $error("need at least two synchroniser stages and a 5-bit address");
   end

   logic [NUM_REGS-1:0][DW-1:0] cfg;

   pclk_regs #(.DW(DW), .AW(AW), .RST_IDX(DIV_REG), .RST_VAL(DIV_RST)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .cfg_o   (cfg)
   );

   logic              byp, dis;
   logic [SEL_W-1:0]  src_field;
   logic [CODE_W-1:0] code_a, code_b;
   logic [SW-1:0]     req_sel;
   logic [CNTW-1:0]   ratio;
   logic              ratio_ok;

   assign byp       = cfg[REG_CLKSEL][BYP_BIT];
   assign dis       = cfg[REG_DIS][GATE_BIT];
   assign src_field = cfg[REG_SRC][SRC_LSB +: SEL_W];
   assign code_a    = cfg[DIV_REG][DIV1_LSB +: CODE_W];
   assign code_b    = cfg[DIV_REG][DIV2_LSB +: CODE_W];

   if (VARIANT == VAR_FULL) begin : g_full
      assign req_sel  = byp ? SW'(XTAL_IDX) : SW'(src_field);
      assign ratio    = CNTW'(code_a) * CNTW'(code_b);
      assign ratio_ok = code_ok(code_a) && code_ok(code_b);
   end else if (VARIANT == VAR_TABLE) begin : g_table
      assign req_sel = byp ? SW'(XTAL_IDX) : SW'(src_field);
      if (TABLE_MODE == TBL_SIX) begin : g_six
         assign ratio    = CNTW'(code_a);
         assign ratio_ok = code_ok(code_a);
      end else if (TABLE_MODE == TBL_ONE_TWO) begin : g_one_two
         assign ratio    = code_a[0] ? CNTW'(2) : CNTW'(1);
         assign ratio_ok = 1'b1;
      end else begin : g_two_four
         assign ratio    = code_a[0] ? CNTW'(4) : CNTW'(2);
         assign ratio_ok = 1'b1;
      end
   end else begin : g_gate
      assign req_sel  = SW'(XTAL_IDX);
      assign ratio    = CNTW'(1);
      assign ratio_ok = 1'b1;
   end

   logic unused_cfg;
   assign unused_cfg = ^{cfg, byp, src_field, code_a, code_b};

   logic src_lvl;

   pclk_srcsel #(.NIN(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_srcsel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  ({xtal_i, ref_clk_i}),
      .sel_i  (cur_sel),
      .lvl_o  (src_lvl)
   );

   logic [SW-1:0]   cur_sel;
   logic            div_q, gate_en, hold;
   logic [CNTW-1:0] act_n;

   pclk_shaper #(.SW(SW), .CNTW(CNTW)) u_shaper (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_lvl_i  (src_lvl),
      .req_sel_i  (req_sel),
      .ratio_i    (ratio),
      .ratio_ok_i (ratio_ok),
      .dis_i      (dis),
      .cur_sel_o  (cur_sel),
      .div_q_o    (div_q),
      .gate_en_o  (gate_en),
      .act_n_o    (act_n),
      .hold_o     (hold),
      .clk_o      (pclk_o)
   );

endmodule

// File: rtl/pclk_chain_chk.sv
module pclk_chain_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       div_q,
   input logic       gate_en,
   input logic       hold,
   input logic       ratio_ok,
   input logic       pclk_o,
   input logic [2:0] cur_sel,
   input logic [5:0] act_n
);

   // R5
   invalid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ratio_ok && !div_q) |=> !div_q);

   // R6
   gate_move_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(gate_en) |-> !$past(div_q));

   // R6
   gated_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pclk_o |-> $past(gate_en));

   // R7
   switch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cur_sel) |-> !$past(div_q));

   // R7
   park_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold |-> !div_q);

   // R8
   ratio_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_n) |-> ($rose(div_q) || $past(hold)));

endmodule

bind pclk_chain pclk_chain_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .div_q    (div_q),
   .gate_en  (gate_en),
   .hold     (hold),
   .ratio_ok (ratio_ok),
   .pclk_o   (pclk_o),
   .cur_sel  (cur_sel),
   .act_n    (act_n)
);

// File: tb/tb_pclk_chain.sv
module tb_pclk_chain;
   import pclk_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ref_clk = 4'b0;
   logic        xtal = 1'b0;
   logic [2:0]  wr = 3'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd0, rd1, rd2;
   logic        pclk0, pclk1, pclk2;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int half_of [4] = '{5, 7, 9, 11};
   localparam int XH = 13;

   always #10 clk = ~clk;

   initial begin #5; forever #100 ref_clk[0] = ~ref_clk[0]; end
   initial begin #5; forever #140 ref_clk[1] = ~ref_clk[1]; end
   initial begin #5; forever #180 ref_clk[2] = ~ref_clk[2]; end
   initial begin #5; forever #220 ref_clk[3] = ~ref_clk[3]; end
   initial begin #5; forever #260 xtal = ~xtal; end

   pclk_chain dut (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .xtal_i(xtal),
      .bus_wr_i(wr[0]), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rd0), .pclk_o(pclk0));

   pclk_chain #(.VARIANT(VAR_TABLE), .TABLE_MODE(TBL_TWO_FOUR)) dut_tbl (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .xtal_i(xtal),
      .bus_wr_i(wr[1]), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rd1), .pclk_o(pclk1));

   pclk_chain #(.VARIANT(VAR_GATE)) dut_gate (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .xtal_i(xtal),
      .bus_wr_i(wr[2]), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rd2), .pclk_o(pclk2));

   function automatic logic pick(int w);
      case (w)
         0: return pclk0;
         1: return pclk1;
         default: return pclk2;
      endcase
   endfunction

   function automatic logic [31:0] rdpick(int w);
      case (w)
         0: return rd0;
         1: return rd1;
         default: return rd2;
      endcase
   endfunction

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic bus_write(int w, logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr[w] = 1'b1;
      @(negedge clk);
      wr[w] = 1'b0;
   endtask

   task automatic bus_read(int w, logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdpick(w);
   endtask

   // width of one full high phase and the low phase after it, in fabric cycles
   task automatic measure(int w, output int hi, output int lo);
      int g = 0;
      @(negedge clk);
      while (pick(w) && g < 4000) begin @(negedge clk); g++; end
      while (!pick(w) && g < 8000) begin @(negedge clk); g++; end
      hi = 0;
      while (pick(w) && hi < 4000) begin hi++; @(negedge clk); end
      lo = 0;
      while (!pick(w) && lo < 4000) begin lo++; @(negedge clk); end
   endtask

   // same as measure, but a register write lands three cycles into the high phase
   task automatic pulse_with_write(int w, logic [4:0] a, logic [31:0] d,
                                   output int hi, output int lo);
      int g = 0;
      @(negedge clk);
      while (pick(w) && g < 4000) begin @(negedge clk); g++; end
      while (!pick(w) && g < 8000) begin @(negedge clk); g++; end
      hi = 0;
      while (pick(w) && hi < 4000) begin
         hi++;
         if (hi == 3) begin addr = a; wdata = d; wr[w] = 1'b1; end
         if (hi == 4) wr[w] = 1'b0;
         @(negedge clk);
      end
      wr[w] = 1'b0;
      lo = 0;
      while (!pick(w) && lo < 600) begin lo++; @(negedge clk); end
   endtask

   task automatic count_high(int w, int n, output int h);
      h = 0;
      repeat (n) begin @(negedge clk); if (pick(w)) h++; end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      int exp_val [6] = '{0, 9, 0, 0, 0, 0};
      repeat (3) @(negedge clk);
      check("R2 output low in reset", int'(pclk0), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         bus_read(0, 5'(4 * i), d);
         check($sformatf("R2 reset value at 0x%0h", 4 * i), int'(d), exp_val[i]);
      end
      bus_read(0, 5'h18, d);
      check("R1 unmapped offset reads zero", int'(d), 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bus_write(0, 5'h08, 32'h5EADBEEF);
      bus_write(0, 5'h0C, 32'h12345678);
      bus_write(0, 5'h10, 32'h0000F0F0);
      bus_read(0, 5'h08, d); check("R1 readback 0x08", int'(d), 32'h5EADBEEF);
      bus_read(0, 5'h0C, d); check("R1 readback 0x0C", int'(d), 32'h12345678);
      bus_read(0, 5'h10, d); check("R1 readback 0x10", int'(d), 32'h0000F0F0);
      bus_write(0, 5'h10, 32'h0);
   endtask

   task automatic t_sources();
      int hi, lo;
      bus_write(0, 5'h04, 32'h09);
      for (int s = 0; s < 4; s++) begin
         bus_write(0, 5'h00, 32'(s));
         measure(0, hi, lo);
         measure(0, hi, lo);
         check($sformatf("R3 source %0d high", s), hi, half_of[s]);
         check($sformatf("R3 source %0d low", s), lo, half_of[s]);
      end
   endtask

   task automatic t_ratio();
      int hi, lo;
      int c1 [4] = '{2, 5, 3, 6};
      int c2 [4] = '{3, 1, 3, 6};
      bus_write(0, 5'h00, 32'h0);
      for (int i = 0; i < 4; i++) begin
         bus_write(0, 5'h04, 32'(c1[i] | (c2[i] << 3)));
         measure(0, hi, lo);
         measure(0, hi, lo);
         check($sformatf("R4 ratio %0dx%0d high", c1[i], c2[i]), hi, c1[i] * c2[i] * 5);
         check($sformatf("R4 ratio %0dx%0d low", c1[i], c2[i]), lo, c1[i] * c2[i] * 5);
      end
   endtask

   task automatic t_invalid();
      int hi, lo;
      bus_write(0, 5'h00, 32'h0);
      bus_write(0, 5'h04, 32'h09);
      measure(0, hi, lo);
      pulse_with_write(0, 5'h04, 32'h0F, hi, lo);
      check("R5 code 7 lets the pulse finish", hi, 5);
      check("R5 code 7 holds output low", lo, 600);
      bus_write(0, 5'h04, 32'h09);
      measure(0, hi, lo);
      pulse_with_write(0, 5'h04, 32'h01, hi, lo);
      check("R5 code 0 in second field holds low", lo, 600);
      bus_write(0, 5'h04, 32'h09);
      measure(0, hi, lo);
      measure(0, hi, lo);
      check("R5 restart after valid codes", hi, 5);
   endtask

   task automatic t_gate();
      int hi, lo;
      bus_write(0, 5'h00, 32'h0);
      bus_write(0, 5'h04, 32'h0C);
      measure(0, hi, lo);
      pulse_with_write(0, 5'h14, 32'h1, hi, lo);
      check("R6 disable keeps current pulse whole", hi, 20);
      check("R6 disable holds output low", lo, 600);
      bus_write(0, 5'h14, 32'h0);
      measure(0, hi, lo);
      measure(0, hi, lo);
      check("R6 clock returns after enable", hi, 20);
   endtask

   task automatic t_switch();
      int hi, lo;
      bit ok = 1;
      bus_write(0, 5'h00, 32'h0);
      bus_write(0, 5'h04, 32'h0A);
      measure(0, hi, lo);
      pulse_with_write(0, 5'h00, 32'h3, hi, lo);
      check("R7 pulse during switch is full", hi, 10);
      for (int i = 0; i < 3; i++) begin
         measure(0, hi, lo);
         if (hi != 10 && hi != 22) ok = 0;
      end
      check("R7 no runt pulse after switch", int'(ok), 1);
      measure(0, hi, lo);
      check("R7 new source high", hi, 22);
      check("R7 new source low", lo, 22);
   endtask

   task automatic t_divchange();
      int hi, lo;
      bus_write(0, 5'h00, 32'h0);
      bus_write(0, 5'h04, 32'h0A);
      measure(0, hi, lo);
      measure(0, hi, lo);
      pulse_with_write(0, 5'h04, 32'h0C, hi, lo);
      check("R8 current high keeps old ratio", hi, 10);
      check("R8 following low keeps old ratio", lo, 10);
      measure(0, hi, lo);
      check("R8 new ratio after rising edge", hi, 20);
   endtask

   task automatic t_bypass();
      int hi, lo;
      bus_write(0, 5'h00, 32'h2);
      bus_write(0, 5'h04, 32'h09);
      bus_write(0, 5'h10, 32'h1);
      measure(0, hi, lo);
      measure(0, hi, lo);
      check("R9 crystal bypass high", hi, XH);
      check("R9 crystal bypass low", lo, XH);
      bus_write(0, 5'h10, 32'h0);
      measure(0, hi, lo);
      measure(0, hi, lo);
      check("R9 bypass off returns to source 2", hi, 9);
   endtask

   task automatic t_table();
      int hi, lo;
      measure(1, hi, lo);
      measure(1, hi, lo);
      check("R10 reset code 1 divides by 4", hi, 20);
      bus_write(1, 5'h04, 32'h3E);
      measure(1, hi, lo);
      measure(1, hi, lo);
      check("R10 code 0 divides by 2, upper bits ignored", hi, 10);
      check("R10 code 0 low phase", lo, 10);
      bus_write(1, 5'h04, 32'h01);
      measure(1, hi, lo);
      measure(1, hi, lo);
      check("R10 code 1 divides by 4", hi, 20);
   endtask

   task automatic t_gate_only();
      int hi, lo, h;
      measure(2, hi, lo);
      measure(2, hi, lo);
      check("R11 crystal passes through", hi, XH);
      bus_write(2, 5'h00, 32'h3);
      bus_write(2, 5'h04, 32'h3F);
      measure(2, hi, lo);
      measure(2, hi, lo);
      check("R11 source and divider words ignored", hi, XH);
      check("R11 low phase unchanged", lo, XH);
      bus_write(2, 5'h14, 32'h1);
      repeat (60) @(negedge clk);
      count_high(2, 300, h);
      check("R11 disable stops gate-only output", h, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got 0 expected 1 (run completed)");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_regs();
      t_sources();
      t_ratio();
      t_invalid();
      t_gate();
      t_switch();
      t_divchange();
      t_bypass();
      t_table();
      t_gate_only();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule